// File: doc/BRIEF.md
# Board Control and Parity Status Register

This block is the 16-bit control and status register that the host sees on a network interface board, together with the logic that records memory parity errors. Software writes it to hold the board in reset, to release the interface from loopback, to ring the network controller's attention line, to enable the two interrupt sources, and to set the memory configuration bits. The same register reports a sticky controller-interrupt flag and a parity-error flag. Both are combined with their enables into one host interrupt request.

When the board's parity checker reports an error, the block records the failing 20-bit address, the bus master that caused it and the failing byte lane, and raises the parity flag. The record is frozen until software writes an acknowledge, so the first error is never overwritten by later ones. The host reaches three registers through a simple word bus. Writes are synchronous. Reads are combinational from the select lines.

Top module: `brd_csr_top`

## Requirements
- R1: In the cycle after a synchronous reset, the status register reads 0x8000 (board held in reset) and `brd_reset` is 1. The parity control register and the address register read 0, and `irq_req` and `attn` are 0.
- R2: A write to select 0 (status) stores bits 15 (board reset), 14 (on-air), 12 (controller interrupt enable), 11 (parity interrupt enable), 5 (expansion memory enable), 4 (256-kbit RAM) and 3:0 (high page bits). These bits drive `brd_reset`, `on_air`, `xmem_en`, `ram256k` and `page_hi` from the next cycle and read back unchanged. Bits 10, 7 and 6 read 0.
- R3: A status write with bit 13 set makes `attn` 1 for exactly the next cycle. Bit 13 always reads 0.
- R4: A `ctrl_irq` pulse sets status bit 8, and the bit stays set. A status write with bit 8 set clears it, unless `ctrl_irq` is high in the same cycle, in which case the bit stays set.
- R5: Status bit 9 is the parity flag. A status write cannot change it.
- R6: A `par_err` event while the parity flag is clear sets the flag. It also stores address bits 19:16 in parity control bits 3:0, address bits 15:0 in the address register (select 2), `par_src` in parity control bit 7 and `par_lane` in parity control bit 6.
- R7: While the parity flag is set and no acknowledge is written, further `par_err` events change neither the flag nor the stored record.
- R8: A write to select 1 with bit 8 set clears the parity flag. Bit 8 reads 0. If `par_err` arrives in the same cycle as the acknowledge, the new error is recorded and the flag stays set.
- R9: `irq_req` = (status bit 8 AND bit 12) OR (status bit 9 AND bit 11), and it follows the stored state within the same cycle.
- R10: Select 3 reads 0. Writes to select 2 or 3 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 parity control, 2 error address low, 3 unused |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for `reg_sel` |
| ctrl_irq | input | 1 | Interrupt pulse from the network controller |
| par_err | input | 1 | Parity error event |
| par_addr | input | 20 | Address of the failing access |
| par_src | input | 1 | Bus master that made the failing access |
| par_lane | input | 1 | Byte lane that failed |
| brd_reset | output | 1 | Board reset |
| on_air | output | 1 | Loopback release |
| attn | output | 1 | One-cycle attention pulse to the controller |
| xmem_en | output | 1 | Expansion memory bus enable |
| ram256k | output | 1 | 256-kbit RAM parts selected |
| page_hi | output | 4 | High page bits |
| irq_req | output | 1 | Combined host interrupt request |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a controller interrupt and a host write that clears the interrupt flag. The second pair is a parity error and a parity acknowledge. The bench drives each pair in the same clock, both in directed steps and many times in a random stretch where events and writes are frequent. A reference model in the bench applies "set wins" to the interrupt flag and "new error recorded" to the acknowledge. Its flags, record and `irq_req` are compared with the design on every clock.

// File: rtl/brd_csr_pkg.sv
package brd_csr_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 20;
    localparam int LO_W   = 16;
    localparam int HI_W   = ADDR_W - LO_W;

    // status bit positions
    localparam int B_RST   = 15;
    localparam int B_AIR   = 14;
    localparam int B_ATTN  = 13;
    localparam int B_IEN   = 12;
    localparam int B_PIEN  = 11;
    localparam int B_PFLAG = 9;
    localparam int B_IFLAG = 8;
    localparam int B_XMEM  = 5;
    localparam int B_R256  = 4;

    // parity control bit positions
    localparam int B_ACK   = 8;
    localparam int B_SRC   = 7;
    localparam int B_LANE  = 6;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_PCTL   = 2'd1,
        SEL_PADDR  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              board_rst;
        logic              on_air;
        logic              ien;
        logic              pien;
        logic              xmem;
        logic              ram256;
        logic [HI_W-1:0]   page_hi;
    } ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              src;
        logic              lane;
    } par_rec_t;

    localparam ctl_t CTL_RESET = '{board_rst: 1'b1, default: '0};

    function automatic ctl_t decode_ctl(input logic [REG_W-1:0] w);
        ctl_t c;
        c.board_rst = w[B_RST];
        c.on_air    = w[B_AIR];
        c.ien       = w[B_IEN];
        c.pien      = w[B_PIEN];
        c.xmem      = w[B_XMEM];
        c.ram256    = w[B_R256];
        c.page_hi   = w[HI_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/brd_ctl_reg.sv
module brd_ctl_reg
    import brd_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_status,
    input  logic [REG_W-1:0] wdata,
    input  logic             irq_pulse,
    output ctl_t             ctl,
    output logic             attn,
    output logic             int_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= CTL_RESET;
            attn     <= 1'b0;
            int_flag <= 1'b0;
        end else begin
            attn <= wr_status && wdata[B_ATTN];
            if (wr_status)
                ctl <= decode_ctl(wdata);
            if (irq_pulse)
                int_flag <= 1'b1;
            else if (wr_status && wdata[B_IFLAG])
                int_flag <= 1'b0;
        end
    end

    AST_ATTN_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        attn |-> $past(wr_status && wdata[B_ATTN])); // R3

    AST_IFLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> int_flag); // R4

endmodule

// File: rtl/brd_par_capture.sv
module brd_par_capture
    import brd_csr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     evt,
    input  par_rec_t evt_rec,
    input  logic     ack,
    output logic     flag,
    output par_rec_t rec
);

    logic take;
    assign take = evt && (!flag || ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            rec  <= '0;
        end else if (take) begin
            flag <= 1'b1;
            rec  <= evt_rec;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end

    AST_PAR_EVENT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag); // R6

    AST_PAR_RECORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack) |=> (flag && $stable(rec))); // R7

    AST_PAR_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !evt) |=> !flag); // R8

endmodule

// File: rtl/brd_csr_top.sv
module brd_csr_top
    import brd_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ctrl_irq,
    input  logic              par_err,
    input  logic [ADDR_W-1:0] par_addr,
    input  logic              par_src,
    input  logic              par_lane,
    output logic              brd_reset,
    output logic              on_air,
    output logic              attn,
    output logic              xmem_en,
    output logic              ram256k,
    output logic [HI_W-1:0]   page_hi,
    output logic              irq_req
);

    reg_sel_e sel;
    ctl_t     ctl;
    par_rec_t rec;
    par_rec_t evt_rec;
    logic     int_flag, par_flag;
    logic     wr_status, wr_pctl;

    assign sel       = reg_sel_e'(reg_sel);
    assign wr_status = reg_wr && (sel == SEL_STATUS);
    assign wr_pctl   = reg_wr && (sel == SEL_PCTL);
    assign evt_rec   = '{addr: par_addr, src: par_src, lane: par_lane};

    brd_ctl_reg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_status (wr_status),
        .wdata     (reg_wdata),
        .irq_pulse (ctrl_irq),
        .ctl       (ctl),
        .attn      (attn),
        .int_flag  (int_flag)
    );

    brd_par_capture u_par (
        .clk     (clk),
        .rst     (rst),
        .evt     (par_err),
        .evt_rec (evt_rec),
        .ack     (wr_pctl && reg_wdata[B_ACK]),
        .flag    (par_flag),
        .rec     (rec)
    );

    assign brd_reset = ctl.board_rst;
    assign on_air    = ctl.on_air;
    assign xmem_en   = ctl.xmem;
    assign ram256k   = ctl.ram256;
    assign page_hi   = ctl.page_hi;
    assign irq_req   = (int_flag && ctl.ien) || (par_flag && ctl.pien);

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STATUS: begin
                reg_rdata[B_RST]    = ctl.board_rst;
                reg_rdata[B_AIR]    = ctl.on_air;
                reg_rdata[B_IEN]    = ctl.ien;
                reg_rdata[B_PIEN]   = ctl.pien;
                reg_rdata[B_PFLAG]  = par_flag;
                reg_rdata[B_IFLAG]  = int_flag;
                reg_rdata[B_XMEM]   = ctl.xmem;
                reg_rdata[B_R256]   = ctl.ram256;
                reg_rdata[HI_W-1:0] = ctl.page_hi;
            end
            SEL_PCTL: begin
                reg_rdata[B_SRC]    = rec.src;
                reg_rdata[B_LANE]   = rec.lane;
                reg_rdata[HI_W-1:0] = rec.addr[ADDR_W-1:LO_W];
            end
            SEL_PADDR: reg_rdata = rec.addr[LO_W-1:0];
            SEL_NONE:  reg_rdata = '0;
        endcase
    end

    AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!ctl.ien && !ctl.pien) |-> !irq_req); // R9

    AST_STATUS_WRITE_KEEPS_PFLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_status && !par_err) |=> (par_flag == $past(par_flag))); // R5

endmodule

// File: tb/tb_brd_csr_top.sv
module tb_brd_csr_top;
    import brd_csr_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_wr;
    logic [1:0]        reg_sel;
    logic [REG_W-1:0]  reg_wdata;
    logic [REG_W-1:0]  reg_rdata;
    logic              ctrl_irq, par_err, par_src, par_lane;
    logic [ADDR_W-1:0] par_addr;
    logic              brd_reset, on_air, attn, xmem_en, ram256k, irq_req;
    logic [HI_W-1:0]   page_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    brd_csr_top dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_irq(ctrl_irq),
        .par_err(par_err), .par_addr(par_addr), .par_src(par_src),
        .par_lane(par_lane), .brd_reset(brd_reset), .on_air(on_air),
        .attn(attn), .xmem_en(xmem_en), .ram256k(ram256k),
        .page_hi(page_hi), .irq_req(irq_req)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [15:0] m_ctl;
    logic        m_if, m_pf, m_attn, m_src, m_lane;
    logic [19:0] m_addr;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0: exp_read = (m_ctl & 16'hD83F) | (16'(m_pf) << 9) | (16'(m_if) << 8);
            2'd1: exp_read = (16'(m_src) << 7) | (16'(m_lane) << 6) | 16'(m_addr[19:16]);
            2'd2: exp_read = m_addr[15:0];
            default: exp_read = 16'h0000;
        endcase
    endfunction

    task automatic model_update(input logic r);
        logic ack;
        if (r) begin
            m_ctl = 16'h8000; m_if = 0; m_pf = 0; m_attn = 0;
            m_src = 0; m_lane = 0; m_addr = '0;
        end else begin
            ack    = reg_wr && reg_sel == 2'd1 && reg_wdata[8];
            m_attn = reg_wr && reg_sel == 2'd0 && reg_wdata[13];
            if (ctrl_irq) m_if = 1;
            else if (reg_wr && reg_sel == 2'd0 && reg_wdata[8]) m_if = 0;
            if (reg_wr && reg_sel == 2'd0) m_ctl = reg_wdata & 16'hD83F;
            if (par_err && (!m_pf || ack)) begin
                m_pf = 1; m_addr = par_addr; m_src = par_src; m_lane = par_lane;
            end else if (ack) m_pf = 0;
        end
    endtask

    task automatic compare_all(input string rtag);
        check(rtag, "reg_rdata", 32'(reg_rdata), 32'(exp_read(reg_sel)));
        check("R9", "irq_req", 32'(irq_req),
              32'((m_if && m_ctl[12]) || (m_pf && m_ctl[11])));
        check("R3", "attn", 32'(attn), 32'(m_attn));
        check("R2", "brd_reset", 32'(brd_reset), 32'(m_ctl[15]));
        check("R2", "on_air", 32'(on_air), 32'(m_ctl[14]));
        check("R2", "xmem_en", 32'(xmem_en), 32'(m_ctl[5]));
        check("R2", "ram256k", 32'(ram256k), 32'(m_ctl[4]));
        check("R2", "page_hi", 32'(page_hi), 32'(m_ctl[3:0]));
    endtask

    // one clock: inputs set at negedge, model steps at the edge, compare at next negedge
    task automatic step(input string rtag, input logic r, input logic w,
                        input logic [1:0] s, input logic [15:0] d,
                        input logic ci, input logic pe, input logic [19:0] pa,
                        input logic ps, input logic pl);
        rst = r; reg_wr = w; reg_sel = s; reg_wdata = d;
        ctrl_irq = ci; par_err = pe; par_addr = pa; par_src = ps; par_lane = pl;
        @(posedge clk);
        model_update(r);
        @(negedge clk);
        compare_all(rtag);
    endtask

    task automatic rd(input string rtag, input logic [1:0] s);
        step(rtag, 0, 0, s, 16'h0, 0, 0, 20'h0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step("R1", 1, 0, 2'd0, 16'h0, 0, 0, 20'h0, 0, 0);
        step("R1", 1, 0, 2'd0, 16'h0, 0, 0, 20'h0, 0, 0);
        rd("R1", 2'd0);
        check("R1", "status after reset", 32'(reg_rdata), 32'h8000);
        rd("R1", 2'd1); rd("R1", 2'd2);

        // R2 control bits, R5 flag bit not writable
        step("R2", 0, 1, 2'd0, 16'hFFFF, 0, 0, 20'h0, 0, 0);
        check("R2", "status masked readback", 32'(reg_rdata), 32'hD83F);
        step("R5", 0, 1, 2'd0, 16'h5A35, 0, 0, 20'h0, 0, 0);
        check("R5", "pflag stays clear", 32'(reg_rdata[9]), 32'h0);
        // R3 attention pulse then clears
        step("R3", 0, 1, 2'd0, 16'h2000, 0, 0, 20'h0, 0, 0);
        check("R3", "attn high", 32'(attn), 32'h1);
        rd("R3", 2'd0);
        check("R3", "attn low", 32'(attn), 32'h0);

        // R4 sticky flag and set-wins collision; R9 irq
        step("R4", 0, 1, 2'd0, 16'h1000, 0, 0, 20'h0, 0, 0);
        step("R4", 0, 0, 2'd0, 16'h0, 1, 0, 20'h0, 0, 0);
        rd("R4", 2'd0); rd("R4", 2'd0);
        check("R9", "irq from ctrl", 32'(irq_req), 32'h1);
        step("R4", 0, 1, 2'd0, 16'h1100, 1, 0, 20'h0, 0, 0);
        check("R4", "set wins over clear", 32'(reg_rdata[8]), 32'h1);
        step("R4", 0, 1, 2'd0, 16'h1100, 0, 0, 20'h0, 0, 0);
        check("R4", "clear", 32'(reg_rdata[8]), 32'h0);

        // R6 capture, R7 hold, R8 ack and collision
        step("R6", 0, 1, 2'd0, 16'h0800, 0, 1, 20'hA1234, 1, 0);
        check("R6", "pflag set", 32'(reg_rdata[9]), 32'h1);
        check("R9", "irq from parity", 32'(irq_req), 32'h1);
        rd("R6", 2'd1);
        check("R6", "pctl record", 32'(reg_rdata), 32'h008A);
        rd("R6", 2'd2);
        check("R6", "low address", 32'(reg_rdata), 32'h1234);
        step("R7", 0, 0, 2'd2, 16'h0, 0, 1, 20'h5FFFF, 0, 1);
        check("R7", "address held", 32'(reg_rdata), 32'h1234);
        step("R10", 0, 1, 2'd2, 16'hBEEF, 0, 0, 20'h0, 0, 0);
        step("R10", 0, 1, 2'd3, 16'hFFFF, 0, 0, 20'h0, 0, 0);
        check("R10", "sel 3 reads 0", 32'(reg_rdata), 32'h0);
        rd("R10", 2'd2);
        step("R8", 0, 1, 2'd1, 16'h0100, 0, 1, 20'h3C0DE, 0, 1);
        check("R8", "collision record", 32'(reg_rdata), 32'h0043);
        step("R8", 0, 1, 2'd1, 16'h0100, 0, 0, 20'h0, 0, 0);
        rd("R8", 2'd0);
        check("R8", "pflag cleared", 32'(reg_rdata[9]), 32'h0);
        step("R6", 0, 0, 2'd2, 16'h0, 0, 1, 20'h07777, 1, 1);
        check("R6", "recapture after ack", 32'(reg_rdata), 32'h7777);

        // random stretch with frequent collisions
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r1 = $urandom;
            logic [31:0] r2 = $urandom;
            step("R4", (r1[9:0] == 0), r1[12] | r1[13], r1[15:14], r2[15:0],
                 r1[16] & r1[17], r1[18] & r1[19], {r1[31:28], r2[31:16]},
                 r1[20], r1[21]);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule